// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface. It owns the command pins from reset until the memory is ready. It brings the device out of power-up with a fixed series of commands: precharge all banks, auto-refresh twice, then load the mode register. After that it tells an access arbiter that normal traffic may start. Until then every idle cycle carries a no-operation command, and clock enable stays high the whole time.

Once the device is ready, the block keeps it refreshed. A free-running interval timer marks one refresh slot per refresh interval, which is the refresh window divided by the refresh count. The sequencer raises a request toward the arbiter a configurable number of cycles before the slot ends. It issues the refresh in the cycle after it samples the grant. If a request waits through a further full interval without a grant, the sequencer issues two refreshes back to back to catch up.

All timings are parameters in picoseconds or nanoseconds. They are converted to clock cycles by rounding up, and the interval is rounded down so that it is never too long.

Top module: `dram_boot_refresh`

## Requirements
- R1: While reset is held, the command pins carry a no-operation, clock enable is high, and both `init_done` and `ref_req` are low.
- R2: The first command after reset is released appears in the first cycle. It is precharge-all: {RAS#,CAS#,WE#} = 3'b010 with address bit 10 high.
- R3: The first auto-refresh ({RAS#,CAS#,WE#} = 3'b001) follows the precharge-all by exactly TRP_CYC cycles.
- R4: The second auto-refresh follows the first by TRFC_CYC cycles. The mode load ({RAS#,CAS#,WE#} = 3'b000) follows the second refresh by TRFC_CYC cycles, with the address equal to `mode_word` and the bank bits zero.
- R5: `init_done` rises exactly 2 cycles after the mode load and then stays high until reset.
- R6: TRP_CYC and TRFC_CYC are the smallest cycle counts whose duration covers the programmed time. The interval REFI_CYC is the interval time (window / count) divided by the clock period and rounded down.
- R7: Every cycle without a command carries a no-operation (3'b111). Chip select is always low and clock enable is always high. The power-up series issues exactly four commands, and after it only auto-refresh is ever issued.
- R8: The first `ref_req` rises REFI_CYC − GRANT_LEAD cycles after `init_done` rises.
- R9: A refresh appears in the cycle after `ref_gnt` is sampled high while a refresh is owed. A grant while nothing is owed issues no command.
- R10: `ref_req` stays high from its rise until TRFC_CYC − 1 cycles after the last refresh of the burst, and then falls.
- R11: If a request is still ungranted when the next interval slot ends, the granted burst contains two refreshes spaced TRFC_CYC cycles apart. Otherwise it contains one.
- R12: Request slots keep a fixed period of REFI_CYC cycles whatever the grant latency. Every rising edge of `ref_req` falls on that grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | ADDR_W | Value placed on the address pins by the mode load |
| ref_gnt | input | 1 | Arbiter grant; the bus is free for refresh |
| init_done | output | 1 | Power-up series complete; normal traffic may start |
| ref_req | output | 1 | Refresh owed or in progress; arbiter must keep the bus idle once it grants |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, held low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address, bit AP_BIT selects all banks on precharge |

## Verification
The bench uses clock-period-indivisible times so that rounding matters. A design that rounded down would issue the second command a cycle early and break the precharge or refresh recovery. A grant is driven while nothing is owed, and any stray refresh from a design that ignored the owed state would show up on the pins. One grant is withheld past the next slot. A design without catch-up would issue a single refresh and fall behind the refresh rate. The remaining grants use varied latencies, which exposes a timer that restarts on grant: its later request edges drift off the fixed period.

// File: rtl/dram_boot_pkg.sv
package dram_boot_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } dram_cmd_e;

  typedef enum logic [2:0] {
    SQ_PREA,
    SQ_REF1,
    SQ_REF2,
    SQ_MRS,
    SQ_SETTLE,
    SQ_RUN
  } seq_state_e;

  // smallest cycle count whose duration covers t_ps
  function automatic int cycles_ceil(longint t_ps, longint clk_ps);
    return int'((t_ps + clk_ps - 1) / clk_ps);
  endfunction

  // refresh interval in cycles, rounded down so it never runs long
  function automatic int refi_cycles(longint window_ns, longint count, longint clk_ps);
    return int'((window_ns * 1000) / (count * clk_ps));
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_refi_timer.sv
module dram_refi_timer #(
  parameter int REFI_CYC = 1562,
  parameter int TRIG_AT  = 1553
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(REFI_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (cnt == CW'(REFI_CYC - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == CW'(TRIG_AT));
endmodule

// File: rtl/dram_refresh_debt.sv
module dram_refresh_debt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       take,
  output logic [1:0] owed,
  output logic       overrun
);
  assign overrun = tick && !take && (owed != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= 2'd0;
    end else if (take) begin
      owed <= tick ? 2'd1 : 2'd0;
    end else if (tick) begin
      owed <= (owed == 2'd0) ? 2'd1 : 2'd2;
    end
  end
endmodule

// File: rtl/dram_cmd_drive.sv
module dram_cmd_drive import dram_boot_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  dram_cmd_e         kind,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BA_W-1:0]   ba_in,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  logic [2:0] cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !issue) begin
      cmd_q   <= CMD_NOP;
      sd_addr <= '0;
      sd_ba   <= '0;
    end else begin
      cmd_q   <= kind;
      sd_addr <= addr_in;
      sd_ba   <= ba_in;
    end
  end

  assign sd_cke   = 1'b1;
  assign sd_cs_n  = 1'b0;
  assign sd_ras_n = cmd_q[2];
  assign sd_cas_n = cmd_q[1];
  assign sd_we_n  = cmd_q[0];
endmodule

// File: rtl/dram_boot_refresh.sv
module dram_boot_refresh import dram_boot_pkg::*; #(
  parameter int ADDR_W            = 12,
  parameter int BA_W              = 2,
  parameter int AP_BIT            = 10,
  parameter int CLK_PS            = 10000,
  parameter int TRP_PS            = 20000,
  parameter int TRFC_PS           = 70000,
  parameter int REFRESH_WINDOW_NS = 64000000,
  parameter int REFRESH_COUNT     = 4096,
  parameter int GRANT_LEAD        = 8,
  parameter int MRD_CYC           = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic              ref_gnt,
  output logic              init_done,
  output logic              ref_req,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int TRP_CYC  = cycles_ceil(TRP_PS, CLK_PS);
  localparam int TRFC_CYC = cycles_ceil(TRFC_PS, CLK_PS);
  localparam int REFI_CYC = refi_cycles(REFRESH_WINDOW_NS, REFRESH_COUNT, CLK_PS);
  localparam int TRIG_AT  = REFI_CYC - 1 - GRANT_LEAD;
  localparam int WAIT_MAX = max3(TRP_CYC, TRFC_CYC, MRD_CYC);
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  wcnt;
  logic              burst_left;
  logic              seq_step;
  logic              interval_tick;
  logic              refresh_start;
  logic              debt_overrun;
  logic [1:0]        owed;
  logic              issue;
  dram_cmd_e         kind;
  logic [ADDR_W-1:0] addr_next;

  dram_refi_timer #(.REFI_CYC(REFI_CYC), .TRIG_AT(TRIG_AT)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (init_done),
    .tick (interval_tick)
  );

  dram_refresh_debt u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (interval_tick),
    .take   (refresh_start),
    .owed   (owed),
    .overrun(debt_overrun)
  );

  assign seq_step      = (wcnt == '0);
  assign refresh_start = seq_step && (state == SQ_RUN) && !burst_left &&
                         (owed != 2'd0) && ref_gnt;
  assign ref_req       = init_done && ((owed != 2'd0) || burst_left || (wcnt != '0));

  always_comb begin
    issue     = 1'b0;
    kind      = CMD_NOP;
    addr_next = '0;
    unique case (state)
      SQ_PREA: begin
        issue             = seq_step;
        kind              = CMD_PRE;
        addr_next[AP_BIT] = 1'b1;
      end
      SQ_REF1, SQ_REF2: begin
        issue = seq_step;
        kind  = CMD_REF;
      end
      SQ_MRS: begin
        issue     = seq_step;
        kind      = CMD_MRS;
        addr_next = mode_word;
      end
      SQ_RUN: begin
        issue = seq_step && (burst_left || refresh_start);
        kind  = CMD_REF;
      end
      default: begin
        issue = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_PREA;
      wcnt       <= '0;
      burst_left <= 1'b0;
      init_done  <= 1'b0;
    end else if (!seq_step) begin
      wcnt <= wcnt - 1'b1;
    end else begin
      unique case (state)
        SQ_PREA: begin
          wcnt  <= CNT_W'(TRP_CYC - 1);
          state <= SQ_REF1;
        end
        SQ_REF1: begin
          wcnt  <= CNT_W'(TRFC_CYC - 1);
          state <= SQ_REF2;
        end
        SQ_REF2: begin
          wcnt  <= CNT_W'(TRFC_CYC - 1);
          state <= SQ_MRS;
        end
        SQ_MRS: begin
          wcnt  <= CNT_W'(MRD_CYC - 1);
          state <= SQ_SETTLE;
        end
        SQ_SETTLE: begin
          init_done <= 1'b1;
          state     <= SQ_RUN;
        end
        SQ_RUN: begin
          if (burst_left) begin
            burst_left <= 1'b0;
            wcnt       <= CNT_W'(TRFC_CYC - 1);
          end else if (refresh_start) begin
            burst_left <= (owed == 2'd2);
            wcnt       <= CNT_W'(TRFC_CYC - 1);
          end
        end
        default: state <= SQ_PREA;
      endcase
    end
  end

  dram_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .kind    (kind),
    .addr_in (addr_next),
    .ba_in   ({BA_W{1'b0}}),
    .sd_cke  (sd_cke),
    .sd_cs_n (sd_cs_n),
    .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n),
    .sd_we_n (sd_we_n),
    .sd_ba   (sd_ba),
    .sd_addr (sd_addr)
  );
endmodule

// File: rtl/dram_boot_refresh_chk.sv
module dram_boot_refresh_chk #(
  parameter int TRP_CYC  = 2,
  parameter int TRFC_CYC = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sd_cke,
  input logic       sd_cs_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic       init_done,
  input logic       ref_req,
  input logic       ref_gnt,
  input logic       refresh_start,
  input logic [1:0] owed
);
  logic [2:0] cmd;
  logic [2:0] last_kind;
  logic [7:0] gap;

  assign cmd = {sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= 8'd0;
      last_kind <= 3'b111;
    end else if (cmd != 3'b111) begin
      gap       <= 8'd1;
      last_kind <= cmd;
    end else if (gap != 8'hFF) begin
      gap <= gap + 8'd1;
    end
  end

  p_pins_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke && !sd_cs_n);

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_mrs_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b000) |=> !init_done);

  p_trp_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'b111 && last_kind == 3'b010) |-> (gap >= 8'(TRP_CYC)));

  p_trfc_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'b111 && last_kind == 3'b001) |-> (gap >= 8'(TRFC_CYC)));

  p_req_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (owed != 2'd0 && !ref_gnt) |=> ref_req);

  p_grant_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_start |=> (cmd == 3'b001));

  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !ref_req) |-> (cmd == 3'b111));
endmodule

bind dram_boot_refresh dram_boot_refresh_chk #(
  .TRP_CYC (TRP_CYC),
  .TRFC_CYC(TRFC_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sd_cke       (sd_cke),
  .sd_cs_n      (sd_cs_n),
  .sd_ras_n     (sd_ras_n),
  .sd_cas_n     (sd_cas_n),
  .sd_we_n      (sd_we_n),
  .init_done    (init_done),
  .ref_req      (ref_req),
  .ref_gnt      (ref_gnt),
  .refresh_start(refresh_start),
  .owed         (owed)
);

// File: tb/dram_boot_refresh_tb.sv
`timescale 1ns/1ps
module dram_boot_refresh_tb;
  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int CLK_PS = 10000;
  localparam int TRP_PS = 25000;
  localparam int TRFC_PS = 65000;
  localparam int WIN_NS = 25600;
  localparam int NREF   = 64;
  localparam int LEAD   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] mode_word = 12'h232;
  logic ref_gnt = 1'b0;
  logic init_done, ref_req, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BA_W-1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dram_boot_refresh #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(10), .CLK_PS(CLK_PS),
    .TRP_PS(TRP_PS), .TRFC_PS(TRFC_PS), .REFRESH_WINDOW_NS(WIN_NS),
    .REFRESH_COUNT(NREF), .GRANT_LEAD(LEAD), .MRD_CYC(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ref_gnt(ref_gnt),
    .init_done(init_done), .ref_req(ref_req), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected timing, worked out independently (R6)
  int trp_c, trfc_c, refi_c;
  int init_cyc[8];
  int init_kind[8];
  int n_init = 0;
  int pre_a10 = 0;
  int mrs_addr = 0;
  int mrs_ba = 0;
  int ref_at[16];
  int n_ref = 0;
  int n_other = 0;
  int rise_at[16];
  int n_rise = 0;
  int fall_at[16];
  int n_fall = 0;
  int gset[16];
  int n_gnt = 0;
  int d_cyc = -1;
  int spur_refs = 0;
  int spur_req = 0;

  function automatic int grant_delay(int idx);
    case (idx)
      0: return 0;
      1: return 3;
      2: return refi_c + 6;
      3: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic bit has_ref(int c);
    for (int i = 0; i < n_ref; i++) if (ref_at[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    int waited;
    int kind;
    bit prev_req;
    int end_cyc;
    int lastref;

    trp_c = 1;
    while (trp_c * CLK_PS < TRP_PS) trp_c++;
    trfc_c = 1;
    while (trfc_c * CLK_PS < TRFC_PS) trfc_c++;
    refi_c = ((WIN_NS * 1000) / NREF) / CLK_PS;

    repeat (3) @(negedge clk);
    // R1 reset state
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 nop", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    check(sd_cke && !sd_cs_n, "R1 cke/cs", {sd_cke, sd_cs_n}, 2);
    check(!init_done && !ref_req, "R1 flags", {init_done, ref_req}, 0);

    rst_n = 1'b1;
    cyc = 0;
    waited = 0;
    prev_req = 1'b0;
    end_cyc = 1000;
    while (cyc < end_cyc) begin
      @(negedge clk);
      cyc++;
      kind = {sd_ras_n, sd_cas_n, sd_we_n};
      if (!(sd_cke && !sd_cs_n)) check(1'b0, "R7 cke/cs", {sd_cke, sd_cs_n}, 2);
      if (kind != 7 && kind != 2 && kind != 1 && kind != 0)
        check(1'b0, "R7 encoding", kind, 7);
      if (d_cyc < 0) begin
        if (kind != 7) begin
          if (n_init < 8) begin
            init_cyc[n_init] = cyc;
            init_kind[n_init] = kind;
          end
          if (kind == 2) pre_a10 = sd_addr[10];
          if (kind == 0) begin
            mrs_addr = sd_addr;
            mrs_ba = sd_ba;
          end
          n_init++;
        end
        if (init_done) begin
          d_cyc = cyc;
          end_cyc = d_cyc + 6 * refi_c + 30;
        end
      end else begin
        if (!init_done) check(1'b0, "R5 sticky", 0, 1);
        if (kind == 1) begin
          if (n_ref < 16) ref_at[n_ref] = cyc;
          n_ref++;
        end else if (kind != 7) n_other++;
      end
      if (ref_req && !prev_req && n_rise < 16) rise_at[n_rise++] = cyc;
      if (!ref_req && prev_req && n_fall < 16) fall_at[n_fall++] = cyc;
      prev_req = ref_req;

      // arbiter model, including a spurious grant window (R9)
      if (d_cyc >= 0 && cyc >= d_cyc + 5 && cyc <= d_cyc + 14) begin
        if (kind == 1) spur_refs++;
        if (ref_req) spur_req++;
        ref_gnt = 1'b1;
      end else if (ref_req) begin
        if (!ref_gnt) begin
          if (waited == grant_delay(n_gnt)) begin
            ref_gnt = 1'b1;
            if (n_gnt < 16) gset[n_gnt] = cyc;
            n_gnt++;
            waited = 0;
          end else waited++;
        end
      end else ref_gnt = 1'b0;
    end

    // power-up series
    check(n_init == 4, "R7 init count", n_init, 4);
    check(init_cyc[0] == 1 && init_kind[0] == 2, "R2 first prea", init_cyc[0], 1);
    check(pre_a10 == 1, "R2 a10", pre_a10, 1);
    check(init_kind[1] == 1 && init_cyc[1] - init_cyc[0] == trp_c, "R3 ref1 after trp",
          init_cyc[1] - init_cyc[0], trp_c);
    check(init_kind[2] == 1 && init_cyc[2] - init_cyc[1] == trfc_c, "R4 ref2 after trfc",
          init_cyc[2] - init_cyc[1], trfc_c);
    check(init_kind[3] == 0 && init_cyc[3] - init_cyc[2] == trfc_c, "R4 mrs after trfc",
          init_cyc[3] - init_cyc[2], trfc_c);
    check(mrs_addr == 32'h232 && mrs_ba == 0, "R4 mrs operand", mrs_addr, 32'h232);
    check(d_cyc - init_cyc[3] == 2, "R5 done delay", d_cyc - init_cyc[3], 2);
    check(trp_c == 3 && trfc_c == 7 && refi_c == 40, "R6 derived counts",
          trp_c * 100 + trfc_c, 307);

    // refresh phase
    check(spur_refs == 0 && spur_req == 0, "R9 grant ignored", spur_refs, 0);
    check(n_other == 0, "R7 only refresh after init", n_other, 0);
    check(n_rise == 5, "R12 rise count", n_rise, 5);
    check(rise_at[0] == d_cyc + refi_c - LEAD, "R8 first request",
          rise_at[0], d_cyc + refi_c - LEAD);
    for (int i = 1; i < n_rise && i < 16; i++)
      check((rise_at[i] - rise_at[0]) % refi_c == 0, "R12 grid",
            rise_at[i] - rise_at[0], refi_c);
    check(n_gnt == 5, "R9 grant count", n_gnt, 5);
    check(n_ref == 6, "R11 total refreshes", n_ref, 6);
    for (int i = 0; i < n_gnt && i < 16; i++) begin
      check(has_ref(gset[i] + 1), "R9 refresh after grant", gset[i] + 1, gset[i] + 1);
      if (i == 2)
        check(has_ref(gset[i] + 1 + trfc_c), "R11 catch-up pair",
              gset[i] + 1 + trfc_c, gset[i] + 1 + trfc_c);
      else
        check(!has_ref(gset[i] + 1 + trfc_c), "R11 single refresh", 1, 0);
      lastref = gset[i] + 1 + ((i == 2) ? trfc_c : 0);
      if (i < n_fall)
        check(fall_at[i] == lastref + trfc_c - 1, "R10 request release",
              fall_at[i], lastref + trfc_c - 1);
      else
        check(1'b0, "R10 request release", -1, lastref + trfc_c - 1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule